// File: doc/BRIEF.md
# Interrupt Entry Bus Sequencer

This block produces the bus traffic a byte-wide 65xx-style processor core generates when it enters an interrupt or a software trap. It watches a reset request, an abort request, an edge-triggered non-maskable request, a maskable level request and two software triggers (break and coprocessor trap). When the sequencer is free it takes the highest-priority request and latches the core's program bank, program counter, status byte and stack pointer. It writes those values onto a descending stack in bank zero, then reads a two-byte vector from bank zero. After that it reports the new program counter for one cycle.

The number of bytes written and the vector table both depend on the mode bit. In native mode four bytes are written and the native vectors are used. In emulation mode three bytes are written and the emulation vectors are used. A reset request writes nothing and always uses the emulation reset vector. The surrounding core decodes instructions, holds each level request until the sequence for it starts, and reloads its registers from `pc_o`, `sp_o` and `i_flag_o` when `done_o` is high. The read data for the vector fetch is supplied combinationally on `rdata_i` in the same cycle as the address.

Top module: `irq_entry_seq`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, the bus is idle: `bus_valid_o`=0, `rw_o`=1, `vp_no`=1 and `done_o`=0.
- R2: In native mode (`emu_i`=1'b0) the sequence starts the cycle after the request is accepted. It makes four write cycles (`rw_o`=0) at bank-0 addresses SP, SP-1, SP-2 and SP-3, writing program bank, PC[15:8], PC[7:0] and status, in that order.
- R3: In emulation mode (`emu_i`=1'b1) there are three write cycles at SP, SP-1 and SP-2, writing PC[15:8], PC[7:0] and status, in that order.
- R4: After the writes come two read cycles at bank-0 address V and then V+1. `vp_no` is low only in those two cycles. In the next cycle `done_o` is high for exactly one cycle, with `pc_o` = {byte read at V+1, byte read at V} and `i_flag_o`=1.
- R5: The vector V is chosen by cause and mode (emulation/native): reset FFFC/FFFC, abort FFF8/FFE8, NMI FFFA/FFEA, IRQ FFFE/FFEE, coprocessor trap FFF4/FFE4, break FFFE/FFE6.
- R6: When several requests are present, the cause taken is the first of: reset (code 0), abort (1), NMI (2), IRQ (3), coprocessor trap (4), break (5). `cause_o` shows this code in the done cycle. Requests that lose wait and are taken in later sequences.
- R7: A low `irq_ni` starts nothing while `i_flag_i`=1. It is taken once `i_flag_i`=0.
- R8: NMI is taken on a high-to-low change of `nmi_ni`. The request stays pending until it is serviced. Holding the pin low afterwards starts no further sequence.
- R9: A reset request needs `res_ni` low for at least two clock edges. The sequence starts on the first cycle that `res_ni` is high again, makes no writes and uses vector FFFC regardless of `emu_i`. A one-cycle low starts nothing. While `res_ni` is low, any sequence in progress is dropped and the bus goes idle.
- R10: In the done cycle `sp_o` equals the latched stack pointer minus the number of bytes written.
- R11: No request is accepted in the done cycle. The next sequence starts no earlier than two cycles after `done_o` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| res_ni | input | 1 | Processor reset request, active low |
| abort_ni | input | 1 | Abort request, active low level |
| nmi_ni | input | 1 | Non-maskable request, falling edge |
| irq_ni | input | 1 | Maskable request, active low level |
| i_flag_i | input | 1 | Interrupt-disable flag from the core |
| emu_i | input | 1 | Mode bit: 1 emulation, 0 native |
| cop_i | input | 1 | Coprocessor trap trigger |
| brk_i | input | 1 | Break trigger |
| pbr_i | input | 8 | Current program bank |
| pc_i | input | 16 | Return program counter |
| p_i | input | 8 | Current status byte |
| sp_i | input | 16 | Current stack pointer |
| rdata_i | input | 8 | Read data for the vector fetch |
| addr_o | output | 24 | Bus address, bank in bits 23:16 |
| wdata_o | output | 8 | Write data |
| rw_o | output | 1 | 1 read, 0 write |
| vp_no | output | 1 | Vector fetch strobe, active low |
| bus_valid_o | output | 1 | Address is valid in this cycle |
| sp_o | output | 16 | Updated stack pointer |
| pc_o | output | 16 | Fetched vector, the new PC |
| cause_o | output | 3 | Code of the cause serviced |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| i_flag_o | output | 1 | Interrupt-disable flag for the core |

## Verification
The bench uses the default `RES_HOLD` of 2. This makes the reset filter boundary testable with short pulses: one low edge must be ignored and two must be accepted. The bench drives random program bank, PC, status, stack pointer and mode for every cause. Directed cases cover the priority chain with all requests raised together, a masked IRQ, an NMI held low, and a reset that arrives in the middle of a sequence. Vector read data comes from an address-derived function, so every vector address leaves its own value in `pc_o`.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int BYTE_W = 8;
  localparam int PC_W   = 2 * BYTE_W;
  localparam int ADDR_W = PC_W + BYTE_W;

  typedef enum logic [2:0] {
    CAUSE_RESET = 3'd0,
    CAUSE_ABORT = 3'd1,
    CAUSE_NMI   = 3'd2,
    CAUSE_IRQ   = 3'd3,
    CAUSE_COP   = 3'd4,
    CAUSE_BRK   = 3'd5
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_VLO  = 2'd2,
    ST_VHI  = 2'd3
  } state_e;

  function automatic logic [PC_W-1:0] vec_addr(cause_e c, logic emu);
    logic [PC_W-1:0] v;
    case (c)
      CAUSE_RESET: v = 16'hFFFC;
      CAUSE_ABORT: v = emu ? 16'hFFF8 : 16'hFFE8;
      CAUSE_NMI:   v = emu ? 16'hFFFA : 16'hFFEA;
      CAUSE_IRQ:   v = emu ? 16'hFFFE : 16'hFFEE;
      CAUSE_COP:   v = emu ? 16'hFFF4 : 16'hFFE4;
      default:     v = emu ? 16'hFFFE : 16'hFFE6;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/irq_entry_req.sv
module irq_entry_req
  import irq_entry_pkg::*;
#(
  parameter int RES_HOLD = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   res_ni,
  input  logic   abort_ni,
  input  logic   nmi_ni,
  input  logic   irq_ni,
  input  logic   i_flag_i,
  input  logic   cop_i,
  input  logic   brk_i,
  input  logic   ready_i,
  output logic   take_o,
  output cause_e cause_o,
  output logic   hold_o
);
  localparam int CNT_W = $clog2(RES_HOLD + 1);

  logic [CNT_W-1:0] res_cnt_q;
  logic             nmi_q, nmi_pend_q;
  logic             res_armed, nmi_edge, nmi_req;

  assign res_armed = (res_cnt_q >= CNT_W'(RES_HOLD));
  assign nmi_edge  = nmi_q & ~nmi_ni;
  assign nmi_req   = nmi_pend_q | nmi_edge;
  assign hold_o    = ~res_ni;

  always_comb begin
    take_o  = 1'b0;
    cause_o = CAUSE_IRQ;
    if (res_ni && ready_i) begin
      take_o = 1'b1;
      if (res_armed)                  cause_o = CAUSE_RESET;
      else if (!abort_ni)             cause_o = CAUSE_ABORT;
      else if (nmi_req)               cause_o = CAUSE_NMI;
      else if (!irq_ni && !i_flag_i)  cause_o = CAUSE_IRQ;
      else if (cop_i)                 cause_o = CAUSE_COP;
      else if (brk_i)                 cause_o = CAUSE_BRK;
      else                            take_o  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_cnt_q  <= '0;
      nmi_q      <= 1'b1;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_q <= nmi_ni;
      if (res_ni)         res_cnt_q <= '0;
      else if (!res_armed) res_cnt_q <= res_cnt_q + 1'b1;
      if (!res_ni) nmi_pend_q <= 1'b0;
      else         nmi_pend_q <= nmi_req & ~(take_o && cause_o == CAUSE_NMI);
    end
  end

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && cause_o == CAUSE_IRQ) |-> !i_flag_i); // R7
  AST_NMI_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_pend_q && res_ni && !(take_o && cause_o == CAUSE_NMI)) |=> nmi_pend_q); // R8
  AST_RES_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && cause_o == CAUSE_RESET) |-> (!$past(res_ni) && res_ni)); // R9
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_entry_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              take_i,
  input  cause_e            cause_i,
  input  logic              emu_i,
  input  logic              i_flag_i,
  input  logic [BYTE_W-1:0] pbr_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [BYTE_W-1:0] p_i,
  input  logic [PC_W-1:0]   sp_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              ready_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              rw_o,
  output logic              vp_no,
  output logic              bus_valid_o,
  output logic [PC_W-1:0]   sp_o,
  output logic [PC_W-1:0]   pc_o,
  output cause_e            cause_o,
  output logic              done_o,
  output logic              i_flag_o
);
  state_e            state_q;
  cause_e            cause_q;
  logic [1:0]        step_q, last_q, idx;
  logic              emu_q, done_q, iflag_q;
  logic [BYTE_W-1:0] pbr_q, p_q, vlo_q;
  logic [PC_W-1:0]   ret_q, sp_q, vec_q, pc_new_q;
  logic              take_emu;

  assign take_emu = (cause_i == CAUSE_RESET) ? 1'b1 : emu_i;
  assign idx      = step_q + {1'b0, emu_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cause_q  <= CAUSE_RESET;
      step_q   <= '0;
      last_q   <= '0;
      emu_q    <= 1'b1;
      done_q   <= 1'b0;
      iflag_q  <= 1'b1;
      pbr_q    <= '0;
      p_q      <= '0;
      vlo_q    <= '0;
      ret_q    <= '0;
      sp_q     <= '0;
      vec_q    <= '0;
      pc_new_q <= '0;
    end else begin
      iflag_q <= (state_q == ST_VHI && !hold_i) ? 1'b1 : i_flag_i;
      if (hold_i) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: begin
            done_q <= 1'b0;
            if (take_i) begin
              cause_q <= cause_i;
              emu_q   <= take_emu;
              pbr_q   <= pbr_i;
              ret_q   <= pc_i;
              p_q     <= p_i;
              sp_q    <= sp_i;
              vec_q   <= vec_addr(cause_i, take_emu);
              step_q  <= '0;
              last_q  <= take_emu ? 2'd2 : 2'd3;
              state_q <= (cause_i == CAUSE_RESET) ? ST_VLO : ST_PUSH;
            end
          end
          ST_PUSH: begin
            sp_q   <= sp_q - 1'b1;
            step_q <= step_q + 1'b1;
            if (step_q == last_q) state_q <= ST_VLO;
          end
          ST_VLO: begin
            vlo_q   <= rdata_i;
            state_q <= ST_VHI;
          end
          default: begin
            pc_new_q <= {rdata_i, vlo_q};
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end
        endcase
      end
    end
  end

  always_comb begin
    addr_o      = '0;
    wdata_o     = '0;
    rw_o        = 1'b1;
    vp_no       = 1'b1;
    bus_valid_o = 1'b1;
    case (state_q)
      ST_PUSH: begin
        addr_o = {{BYTE_W{1'b0}}, sp_q};
        rw_o   = 1'b0;
        case (idx)
          2'd0:    wdata_o = pbr_q;
          2'd1:    wdata_o = ret_q[PC_W-1:BYTE_W];
          2'd2:    wdata_o = ret_q[BYTE_W-1:0];
          default: wdata_o = p_q;
        endcase
      end
      ST_VLO: begin
        addr_o = {{BYTE_W{1'b0}}, vec_q};
        vp_no  = 1'b0;
      end
      ST_VHI: begin
        addr_o = {{BYTE_W{1'b0}}, vec_q | {{(PC_W-1){1'b0}}, 1'b1}};
        vp_no  = 1'b0;
      end
      default: bus_valid_o = 1'b0;
    endcase
  end

  assign ready_o  = (state_q == ST_IDLE) && !done_q;
  assign sp_o     = sp_q;
  assign pc_o     = pc_new_q;
  assign cause_o  = cause_q;
  assign done_o   = done_q;
  assign i_flag_o = iflag_q;

  AST_NO_TAKE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !take_i); // R11
  AST_SP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PUSH && !hold_i) |=> (sp_q == $past(sp_q) - 1'b1)); // R10
  AST_WRITE_BANK0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !rw_o) |-> (addr_o[ADDR_W-1:PC_W] == '0)); // R2
  AST_VP_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vp_no |-> (rw_o && addr_o[ADDR_W-1:PC_W] == '0 && addr_o[PC_W-1:5] == 11'h7FF)); // R5
  AST_VLO_VHI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_VLO && !hold_i) |=> (state_q == ST_VHI)); // R4
  AST_DONE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_DONE_IFLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (i_flag_o && vp_no)); // R4
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int RES_HOLD = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        res_ni,
  input  logic        abort_ni,
  input  logic        nmi_ni,
  input  logic        irq_ni,
  input  logic        i_flag_i,
  input  logic        emu_i,
  input  logic        cop_i,
  input  logic        brk_i,
  input  logic [7:0]  pbr_i,
  input  logic [15:0] pc_i,
  input  logic [7:0]  p_i,
  input  logic [15:0] sp_i,
  input  logic [7:0]  rdata_i,
  output logic [23:0] addr_o,
  output logic [7:0]  wdata_o,
  output logic        rw_o,
  output logic        vp_no,
  output logic        bus_valid_o,
  output logic [15:0] sp_o,
  output logic [15:0] pc_o,
  output logic [2:0]  cause_o,
  output logic        done_o,
  output logic        i_flag_o
);
  logic   ready, take, hold;
  cause_e take_cause, done_cause;

  irq_entry_req #(.RES_HOLD(RES_HOLD)) u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .res_ni   (res_ni),
    .abort_ni (abort_ni),
    .nmi_ni   (nmi_ni),
    .irq_ni   (irq_ni),
    .i_flag_i (i_flag_i),
    .cop_i    (cop_i),
    .brk_i    (brk_i),
    .ready_i  (ready),
    .take_o   (take),
    .cause_o  (take_cause),
    .hold_o   (hold)
  );

  irq_entry_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_i      (hold),
    .take_i      (take),
    .cause_i     (take_cause),
    .emu_i       (emu_i),
    .i_flag_i    (i_flag_i),
    .pbr_i       (pbr_i),
    .pc_i        (pc_i),
    .p_i         (p_i),
    .sp_i        (sp_i),
    .rdata_i     (rdata_i),
    .ready_o     (ready),
    .addr_o      (addr_o),
    .wdata_o     (wdata_o),
    .rw_o        (rw_o),
    .vp_no       (vp_no),
    .bus_valid_o (bus_valid_o),
    .sp_o        (sp_o),
    .pc_o        (pc_o),
    .cause_o     (done_cause),
    .done_o      (done_o),
    .i_flag_o    (i_flag_o)
  );

  assign cause_o = done_cause;

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_ni |=> !bus_valid_o); // R9
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_n = 1'b1, abort_n = 1'b1, nmi_n = 1'b1, irq_n = 1'b1;
  logic        iflag = 1'b1, emu = 1'b1, cop = 1'b0, brk = 1'b0;
  logic [7:0]  pbr = '0, p = '0;
  logic [15:0] pc = '0, sp = '0;
  logic [7:0]  rdata;
  logic [23:0] addr;
  logic [7:0]  wdata;
  logic        rw, vp_n, bvalid, done, iflag_o;
  logic [15:0] sp_o, pc_o;
  logic [2:0]  cause_o;
  int          n_chk = 0, n_fail = 0, cycles = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] mem_byte(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign rdata = mem_byte(addr);

  irq_entry_seq u_irq_entry_seq (
    .clk_i(clk), .rst_ni(rst_n), .res_ni(res_n), .abort_ni(abort_n),
    .nmi_ni(nmi_n), .irq_ni(irq_n), .i_flag_i(iflag), .emu_i(emu),
    .cop_i(cop), .brk_i(brk), .pbr_i(pbr), .pc_i(pc), .p_i(p), .sp_i(sp),
    .rdata_i(rdata), .addr_o(addr), .wdata_o(wdata), .rw_o(rw), .vp_no(vp_n),
    .bus_valid_o(bvalid), .sp_o(sp_o), .pc_o(pc_o), .cause_o(cause_o),
    .done_o(done), .i_flag_o(iflag_o)
  );

  function automatic logic [15:0] exp_vec(int c, logic e);
    case (c)
      0: return 16'hFFFC;
      1: return e ? 16'hFFF8 : 16'hFFE8;
      2: return e ? 16'hFFFA : 16'hFFEA;
      3: return e ? 16'hFFFE : 16'hFFEE;
      4: return e ? 16'hFFF4 : 16'hFFE4;
      default: return e ? 16'hFFFE : 16'hFFE6;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Called at the negedge where a request is visible; checks the whole sequence.
  task automatic run_entry(input int c, input logic keep_irq, input logic keep_nmi);
    logic        e;
    int          npush;
    logic [7:0]  b [4];
    logic [15:0] v;
    e     = (c == 0) ? 1'b1 : emu;
    npush = (c == 0) ? 0 : (e ? 3 : 4);
    b[0] = pbr; b[1] = pc[15:8]; b[2] = pc[7:0]; b[3] = p;
    v = exp_vec(c, e);
    @(negedge clk);
    abort_n = 1'b1; cop = 1'b0; brk = 1'b0;
    if (!keep_nmi) nmi_n = 1'b1;
    if (!keep_irq) irq_n = 1'b1;
    for (int k = 0; k < npush; k++) begin
      chk(e ? "R3 push addr" : "R2 push addr", {8'b0, addr}, {8'b0, 8'h00, sp - 16'(k)});
      chk(e ? "R3 push data" : "R2 push data", {24'b0, wdata}, {24'b0, b[k + (e ? 1 : 0)]});
      chk("R2 write strobe", {30'b0, rw, vp_n}, 32'h1);
      @(negedge clk);
    end
    chk("R5 vector low addr", {8'b0, addr}, {16'b0, v});
    chk("R4 vector low strobes", {30'b0, rw, vp_n}, 32'h2);
    @(negedge clk);
    chk("R5 vector high addr", {8'b0, addr}, {16'b0, v + 16'd1});
    chk("R4 vector high strobes", {30'b0, rw, vp_n}, 32'h2);
    @(negedge clk);
    chk("R4 done", {29'b0, done, vp_n, bvalid}, 32'h6);
    chk("R4 new pc", {16'b0, pc_o},
        {16'b0, mem_byte({8'h00, v + 16'd1}), mem_byte({8'h00, v})});
    chk("R4 iflag", {31'b0, iflag_o}, 32'h1);
    chk("R10 sp", {16'b0, sp_o}, {16'b0, sp - 16'(npush)});
    chk("R6 cause", {29'b0, cause_o}, c);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", {28'b0, bvalid, rw, vp_n, done}, 32'h6);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle released", {28'b0, bvalid, rw, vp_n, done}, 32'h6);

    // R9 one-cycle low is filtered
    res_n = 1'b0;
    @(negedge clk);
    res_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9 short pulse ignored", {31'b0, bvalid}, 32'h0);
    end

    // R9 proper reset, native mode input still yields emulation vector
    emu = 1'b0; sp = 16'h01F0;
    res_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    res_n = 1'b1;
    run_entry(0, 1'b0, 1'b0);
    @(negedge clk);

    // R7 masked IRQ
    iflag = 1'b1; irq_n = 1'b0; emu = 1'b1; pc = 16'h1234; p = 8'h24; sp = 16'h01FF;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R7 masked irq idle", {31'b0, bvalid}, 32'h0);
    end
    iflag = 1'b0;
    run_entry(3, 1'b0, 1'b0);
    @(negedge clk);

    // R6 priority with everything raised; R8/R11 pending NMI after abort
    emu = 1'b0; pbr = 8'h7E; pc = 16'hC0DE; p = 8'h31; sp = 16'h2000;
    abort_n = 1'b0; nmi_n = 1'b0; irq_n = 1'b0; cop = 1'b1; brk = 1'b1;
    run_entry(1, 1'b1, 1'b1);
    cop = 1'b1; brk = 1'b1;
    @(negedge clk);
    run_entry(2, 1'b1, 1'b1);
    cop = 1'b1; brk = 1'b1;
    @(negedge clk);
    run_entry(3, 1'b0, 1'b1);
    cop = 1'b1; brk = 1'b1;
    @(negedge clk);
    run_entry(4, 1'b0, 1'b1);
    brk = 1'b1;
    @(negedge clk);
    run_entry(5, 1'b0, 1'b1);
    // R8 NMI still held low: no retrigger
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R8 nmi level ignored", {31'b0, bvalid}, 32'h0);
    end
    nmi_n = 1'b1;
    @(negedge clk);

    // R9 reset abandons a running sequence
    irq_n = 1'b0; emu = 1'b0; sp = 16'h0150;
    @(negedge clk);
    irq_n = 1'b1; res_n = 1'b0;
    @(negedge clk);
    chk("R9 sequence dropped", {31'b0, bvalid}, 32'h0);
    @(negedge clk);
    res_n = 1'b1;
    run_entry(0, 1'b0, 1'b0);
    @(negedge clk);

    // random scenarios
    for (int it = 0; it < 40; it++) begin
      int c;
      emu = 1'($urandom);
      pbr = 8'($urandom); pc = 16'($urandom); p = 8'($urandom); sp = 16'($urandom);
      c = 1 + int'($urandom % 5);
      iflag = (c == 3) ? 1'b0 : 1'($urandom);
      case (c)
        1: abort_n = 1'b0;
        2: nmi_n = 1'b0;
        3: irq_n = 1'b0;
        4: cop = 1'b1;
        default: brk = 1'b1;
      endcase
      run_entry(c, 1'b0, 1'b0);
      @(negedge clk);
    end

    finish_run();
  end
endmodule